// File: doc/BRIEF.md
# Programmable Nearest-Neighbor Switchbox

This block is the routing switchbox of one tile in a tiled reconfigurable fabric. The tile has four sides (left, right, top, bottom), and each side carries three bus tracks toward the neighbouring tile. Configuration bits decide which source drives each outgoing track. A source can be a track of the same index arriving on another side, which gives a turn or a straight pass-through. It can also be the local logic unit's result, or the vertical port that links track 0 of a side to the switchbox stacked directly above or below. The same bits also pick which incoming track feeds each operand input of the local logic unit.

The routing is modelled as directional multiplexers. Every output has a data word and a valid bit, and an output whose code selects nothing drives zero with its valid bit low. Configuration is loaded serially into a shadow register and then committed in one step to the active register that steers the routing. Shifting a new pattern in therefore never disturbs the paths in use. The data path itself is purely combinational.

Top module: `nn_switchbox`

## Requirements
- R1: Each side has three tracks. Bus index = side*3 + track, with sides numbered left=0, right=1, top=2, bottom=3. `busIn`/`busOut` word i sits at bits [i*WIDTH +: WIDTH], and `vertIn`/`vertOut` word s belongs to side s.
- R2: While `cfgShift` is high, each clock edge shifts `cfgIn` into the top of a 56-bit shadow register and moves the other bits one place toward bit 0, so the first bit shifted lands in bit 0 after 56 shifts. A `cfgCommit` pulse copies the shadow into the active configuration. Shifting without a commit has no effect on any output.
- R3: Active configuration layout: bits [3*i +: 3] hold the code of bus output i. Bits [36+3*s +: 3] hold the code of vertical output s. Bits [48+4*k +: 4] hold the code of logic operand k.
- R4: Bus output code for side s, track t: 1..4 selects incoming track t of side code-1 (a turn, or a pass-through from the opposite side). A code equal to s+1 (own side) is undriven. Code 5 selects the logic result. Code 6 selects vertical input s, but only when t is 0; otherwise it is undriven. Codes 0 and 7 are undriven.
- R5: Turns are disjoint: a bus output of track t never carries data from an incoming track of another index.
- R6: Vertical output code for side s: 1..4 selects incoming track 0 of side code-1, and 5 selects the logic result. Codes 0, 6 and 7 are undriven.
- R7: Logic operand code: 1..12 selects incoming bus code-1. Codes 0 and 13..15 are undriven.
- R8: An undriven output drives all-zero data with its valid bit low. A driven output has its valid bit high.
- R9: Reset clears both the shadow and the active configuration, so all outputs are undriven afterwards, including after a commit with no shifting.
- R10: Outputs follow data inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgIn | input | 1 | Serial configuration bit |
| cfgShift | input | 1 | Shift enable for the shadow register |
| cfgCommit | input | 1 | Copy shadow into active configuration |
| busIn | input | 192 | Incoming tracks from the neighbours, 12 words |
| busOut | output | 192 | Outgoing tracks toward the neighbours, 12 words |
| busValid | output | 12 | Driven flag per outgoing track |
| vertIn | input | 64 | Vertical port inputs, one word per side |
| vertOut | output | 64 | Vertical port outputs, one word per side |
| vertValid | output | 4 | Driven flag per vertical output |
| logicResult | input | 16 | Result word from the local logic unit |
| logicOperand | output | 32 | Operand words to the local logic unit, 2 words |
| logicOperandValid | output | 2 | Driven flag per operand |

## Verification
Uniform sweeps put the same code on every output at once, for every code value, so that each selection rule is tried on every side and track, including the own-side and off-track codes that must stay undriven. Mixed patterns give neighbouring outputs different codes, which separates a correct per-output field position from a shifted or swapped field. Every source word carries a distinct value, so a wrong track, side or vertical pick shows up as a data mismatch rather than only a valid-bit error. Separate cases shift a new pattern in without committing it, and reset the block and then commit, to confirm that only committed, non-reset state steers the routing.

// File: rtl/nn_switchbox_pkg.sv
package nn_switchbox_pkg;
  localparam int SIDES      = 4;
  localparam int SIDE_SEL_W = 3;

  localparam logic [SIDE_SEL_W-1:0] CODE_NONE  = 3'd0;
  localparam logic [SIDE_SEL_W-1:0] CODE_LOGIC = 3'd5;
  localparam logic [SIDE_SEL_W-1:0] CODE_VERT  = 3'd6;

  typedef struct packed {
    logic shift;
    logic commit;
  } cfg_strobe_t;
endpackage

// File: rtl/nn_switchbox_cfg.sv
module nn_switchbox_cfg
  import nn_switchbox_pkg::*;
#(
  parameter int CFG_W = 56
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgIn,
  input  cfg_strobe_t      strobe,
  output logic [CFG_W-1:0] activeCfg
);
  logic [CFG_W-1:0] shadowCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCfg <= '0;
      activeCfg <= '0;
    end else begin
      if (strobe.shift)  shadowCfg <= {cfgIn, shadowCfg[CFG_W-1:1]};
      if (strobe.commit) activeCfg <= shadowCfg;
    end
  end

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(activeCfg)); // R2
  AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shift |=> $stable(shadowCfg)); // R2
endmodule

// File: rtl/nn_switchbox_route.sv
module nn_switchbox_route
  import nn_switchbox_pkg::*;
#(
  parameter int TRACKS       = 3,
  parameter int WIDTH        = 16,
  parameter int LOGIC_INPUTS = 2,
  parameter int VERT_TRACK   = 0,
  parameter int LOGIC_SEL_W  = 4,
  parameter int CFG_W        = 56
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [CFG_W-1:0]              activeCfg,
  input  logic [SIDES*TRACKS*WIDTH-1:0] busIn,
  output logic [SIDES*TRACKS*WIDTH-1:0] busOut,
  output logic [SIDES*TRACKS-1:0]       busValid,
  input  logic [SIDES*WIDTH-1:0]        vertIn,
  output logic [SIDES*WIDTH-1:0]        vertOut,
  output logic [SIDES-1:0]              vertValid,
  input  logic [WIDTH-1:0]              logicResult,
  output logic [LOGIC_INPUTS*WIDTH-1:0] logicOperand,
  output logic [LOGIC_INPUTS-1:0]       logicOperandValid
);
  localparam int NUM_BUS   = SIDES * TRACKS;
  localparam int VERT_BASE = NUM_BUS * SIDE_SEL_W;
  localparam int LOGIC_BASE = VERT_BASE + SIDES * SIDE_SEL_W;

  logic [WIDTH-1:0] busInA  [NUM_BUS];
  logic [WIDTH-1:0] vertInA [SIDES];

  for (genvar i = 0; i < NUM_BUS; i++) begin : gUnpackBus
    assign busInA[i] = busIn[i*WIDTH +: WIDTH];
  end
  for (genvar s = 0; s < SIDES; s++) begin : gUnpackVert
    assign vertInA[s] = vertIn[s*WIDTH +: WIDTH];
  end

  // R1 R5: side outputs; track t only ever draws from track t
  for (genvar s = 0; s < SIDES; s++) begin : gSide
    for (genvar t = 0; t < TRACKS; t++) begin : gTrack
      localparam int IDX = s * TRACKS + t;
      logic [SIDE_SEL_W-1:0] code;
      logic [WIDTH-1:0]      d;
      logic                  v;
      assign code = activeCfg[IDX*SIDE_SEL_W +: SIDE_SEL_W];
      always_comb begin
        d = '0;
        v = 1'b0;
        for (int j = 0; j < SIDES; j++) begin
          if (int'(code) == j + 1 && j != s) begin
            d = busInA[j*TRACKS + t];
            v = 1'b1;
          end
        end
        if (code == CODE_LOGIC) begin
          d = logicResult;
          v = 1'b1;
        end else if (code == CODE_VERT && t == VERT_TRACK) begin
          d = vertInA[s];
          v = 1'b1;
        end
      end
      assign busOut[IDX*WIDTH +: WIDTH] = d;
      assign busValid[IDX] = v;

      AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        !busValid[IDX] |-> busOut[IDX*WIDTH +: WIDTH] == '0); // R8
      AST_NO_SELF_LOOP: assert property (@(posedge clk) disable iff (!rstN)
        int'(code) == s + 1 |-> !busValid[IDX]); // R4
      AST_VERT_TRACK_ONLY: assert property (@(posedge clk) disable iff (!rstN)
        (code == CODE_VERT && t != VERT_TRACK) |-> !busValid[IDX]); // R4
      AST_NONE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rstN)
        code == CODE_NONE |-> !busValid[IDX]); // R4
    end
  end

  // R6: vertical outputs
  for (genvar s = 0; s < SIDES; s++) begin : gVert
    logic [SIDE_SEL_W-1:0] code;
    logic [WIDTH-1:0]      d;
    logic                  v;
    assign code = activeCfg[VERT_BASE + s*SIDE_SEL_W +: SIDE_SEL_W];
    always_comb begin
      d = '0;
      v = 1'b0;
      for (int j = 0; j < SIDES; j++) begin
        if (int'(code) == j + 1) begin
          d = busInA[j*TRACKS + VERT_TRACK];
          v = 1'b1;
        end
      end
      if (code == CODE_LOGIC) begin
        d = logicResult;
        v = 1'b1;
      end
    end
    assign vertOut[s*WIDTH +: WIDTH] = d;
    assign vertValid[s] = v;

    AST_VERT_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !vertValid[s] |-> vertOut[s*WIDTH +: WIDTH] == '0); // R8
  end

  // R7: logic operand taps
  for (genvar k = 0; k < LOGIC_INPUTS; k++) begin : gOperand
    logic [LOGIC_SEL_W-1:0] code;
    logic [WIDTH-1:0]       d;
    logic                   v;
    assign code = activeCfg[LOGIC_BASE + k*LOGIC_SEL_W +: LOGIC_SEL_W];
    always_comb begin
      d = '0;
      v = 1'b0;
      for (int j = 0; j < NUM_BUS; j++) begin
        if (int'(code) == j + 1) begin
          d = busInA[j];
          v = 1'b1;
        end
      end
    end
    assign logicOperand[k*WIDTH +: WIDTH] = d;
    assign logicOperandValid[k] = v;

    AST_OPERAND_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      int'(code) > NUM_BUS |-> !logicOperandValid[k]); // R7
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (busValid == '0 && vertValid == '0 && logicOperandValid == '0)); // R9
endmodule

// File: rtl/nn_switchbox.sv
module nn_switchbox
  import nn_switchbox_pkg::*;
#(
  parameter int TRACKS       = 3,
  parameter int WIDTH        = 16,
  parameter int LOGIC_INPUTS = 2,
  parameter int VERT_TRACK   = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgIn,
  input  logic                          cfgShift,
  input  logic                          cfgCommit,
  input  logic [SIDES*TRACKS*WIDTH-1:0] busIn,
  output logic [SIDES*TRACKS*WIDTH-1:0] busOut,
  output logic [SIDES*TRACKS-1:0]       busValid,
  input  logic [SIDES*WIDTH-1:0]        vertIn,
  output logic [SIDES*WIDTH-1:0]        vertOut,
  output logic [SIDES-1:0]              vertValid,
  input  logic [WIDTH-1:0]              logicResult,
  output logic [LOGIC_INPUTS*WIDTH-1:0] logicOperand,
  output logic [LOGIC_INPUTS-1:0]       logicOperandValid
);
  localparam int NUM_BUS     = SIDES * TRACKS;
  localparam int LOGIC_SEL_W = $clog2(NUM_BUS + 1);
  localparam int CFG_W       = (NUM_BUS + SIDES) * SIDE_SEL_W + LOGIC_INPUTS * LOGIC_SEL_W;

  cfg_strobe_t      strobe;
  logic [CFG_W-1:0] activeCfg;

  assign strobe.shift  = cfgShift;
  assign strobe.commit = cfgCommit;

  nn_switchbox_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk       (clk),
    .rstN      (rstN),
    .cfgIn     (cfgIn),
    .strobe    (strobe),
    .activeCfg (activeCfg)
  );

  nn_switchbox_route #(
    .TRACKS       (TRACKS),
    .WIDTH        (WIDTH),
    .LOGIC_INPUTS (LOGIC_INPUTS),
    .VERT_TRACK   (VERT_TRACK),
    .LOGIC_SEL_W  (LOGIC_SEL_W),
    .CFG_W        (CFG_W)
  ) u_route (
    .clk               (clk),
    .rstN              (rstN),
    .activeCfg         (activeCfg),
    .busIn             (busIn),
    .busOut            (busOut),
    .busValid          (busValid),
    .vertIn            (vertIn),
    .vertOut           (vertOut),
    .vertValid         (vertValid),
    .logicResult       (logicResult),
    .logicOperand      (logicOperand),
    .logicOperandValid (logicOperandValid)
  );
endmodule

// File: tb/nn_switchbox_bench.sv
module nn_switchbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NB = 12;
  localparam int NS = 4;
  localparam int NL = 2;
  localparam int CFG_W = 56;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgIn = 1'b0;
  logic cfgShift = 1'b0;
  logic cfgCommit = 1'b0;
  logic [NB*W-1:0] busIn = '0;
  logic [NB*W-1:0] busOut;
  logic [NB-1:0]   busValid;
  logic [NS*W-1:0] vertIn = '0;
  logic [NS*W-1:0] vertOut;
  logic [NS-1:0]   vertValid;
  logic [W-1:0]    logicResult = '0;
  logic [NL*W-1:0] logicOperand;
  logic [NL-1:0]   logicOperandValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nn_switchbox u_nn_switchbox (
    .clk(clk), .rstN(rstN), .cfgIn(cfgIn), .cfgShift(cfgShift), .cfgCommit(cfgCommit),
    .busIn(busIn), .busOut(busOut), .busValid(busValid),
    .vertIn(vertIn), .vertOut(vertOut), .vertValid(vertValid),
    .logicResult(logicResult), .logicOperand(logicOperand),
    .logicOperandValid(logicOperandValid)
  );

  // source ids: bus 0..11, vertical 12..15, logic result 16
  function automatic logic [W-1:0] srcVal(int p, int id);
    return 16'((p + 1) * 16'h1357) ^ 16'((id + 1) * 16'h0F1D);
  endfunction

  // R3 layout
  function automatic logic [CFG_W-1:0] mkCfg(int seed, bit uniform);
    logic [CFG_W-1:0] c = '0;
    for (int i = 0; i < NB; i++) c[i*3 +: 3] = 3'(uniform ? seed % 8 : (i*3 + seed) % 8);
    for (int s = 0; s < NS; s++) c[36 + s*3 +: 3] = 3'(uniform ? seed % 8 : (s*5 + seed + 1) % 8);
    for (int k = 0; k < NL; k++) c[48 + k*4 +: 4] = 4'(uniform ? seed % 16 : (k*7 + seed*3) % 16);
    return c;
  endfunction

  // R4 R5 model
  function automatic logic [W:0] expBus(logic [CFG_W-1:0] c, int p, int s, int t);
    int code = int'(c[(s*3 + t)*3 +: 3]);
    if (code >= 1 && code <= 4 && code - 1 != s) return {1'b1, srcVal(p, (code-1)*3 + t)};
    if (code == 5) return {1'b1, srcVal(p, 16)};
    if (code == 6 && t == 0) return {1'b1, srcVal(p, 12 + s)};
    return '0;
  endfunction

  // R6 model
  function automatic logic [W:0] expVert(logic [CFG_W-1:0] c, int p, int s);
    int code = int'(c[36 + s*3 +: 3]);
    if (code >= 1 && code <= 4) return {1'b1, srcVal(p, (code-1)*3)};
    if (code == 5) return {1'b1, srcVal(p, 16)};
    return '0;
  endfunction

  // R7 model
  function automatic logic [W:0] expOper(logic [CFG_W-1:0] c, int p, int k);
    int code = int'(c[48 + k*4 +: 4]);
    if (code >= 1 && code <= 12) return {1'b1, srcVal(p, code - 1)};
    return '0;
  endfunction

  task automatic setInputs(int p);
    for (int i = 0; i < NB; i++) busIn[i*W +: W] = srcVal(p, i);
    for (int s = 0; s < NS; s++) vertIn[s*W +: W] = srcVal(p, 12 + s);
    logicResult = srcVal(p, 16);
  endtask

  task automatic check(string req, logic [W:0] act, logic [W:0] exp, int idx);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s output %0d: actual valid=%0b data=%h expected valid=%0b data=%h",
               req, idx, act[W], act[W-1:0], exp[W], exp[W-1:0]);
    end
  endtask

  // R8: undriven entries in the models are all-zero with valid low
  // R10: checked with no clock edge after the inputs change
  task automatic checkAll(logic [CFG_W-1:0] c, int p, string tag);
    setInputs(p);
    #1;
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < 3; t++)
        check({tag, " R4"}, {busValid[s*3+t], busOut[(s*3+t)*W +: W]}, expBus(c, p, s, t), s*3+t);
    for (int s = 0; s < NS; s++)
      check({tag, " R6"}, {vertValid[s], vertOut[s*W +: W]}, expVert(c, p, s), s);
    for (int k = 0; k < NL; k++)
      check({tag, " R7"}, {logicOperandValid[k], logicOperand[k*W +: W]}, expOper(c, p, k), k);
  endtask

  // R2: serial shift, first bit lands in bit 0
  task automatic shiftCfg(logic [CFG_W-1:0] c);
    for (int i = 0; i < CFG_W; i++) begin
      @(negedge clk);
      cfgIn = c[i];
      cfgShift = 1'b1;
    end
    @(negedge clk);
    cfgShift = 1'b0;
    cfgIn = 1'b0;
  endtask

  task automatic commitCfg();
    cfgCommit = 1'b1;
    @(negedge clk);
    cfgCommit = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CFG_W-1:0] cfgA;
    logic [CFG_W-1:0] cfgB;
    repeat (3) @(negedge clk);
    // R9 reset state
    checkAll('0, 0, "R9 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll('0, 1, "R9 after release");

    // R1 R3 R4 R5 R6 R7 R8: mixed patterns
    for (int seed = 0; seed < 8; seed++) begin
      cfgA = mkCfg(seed, 1'b0);
      shiftCfg(cfgA);
      commitCfg();
      for (int p = 0; p < 3; p++) checkAll(cfgA, p + seed, "mixed");
    end
    // uniform code sweep over every code value
    for (int code = 0; code < 16; code++) begin
      cfgA = mkCfg(code, 1'b1);
      shiftCfg(cfgA);
      commitCfg();
      for (int p = 0; p < 3; p++) checkAll(cfgA, p + 20, "uniform");
    end

    // R2: shifting without commit leaves routing alone
    cfgA = mkCfg(2, 1'b0);
    cfgB = mkCfg(5, 1'b1);
    shiftCfg(cfgA);
    commitCfg();
    shiftCfg(cfgB);
    checkAll(cfgA, 40, "R2 no commit");
    commitCfg();
    checkAll(cfgB, 41, "R2 after commit");

    // R9: reset mid-run clears shadow too
    shiftCfg(cfgA);
    rstN = 1'b0;
    @(negedge clk);
    checkAll('0, 42, "R9 in reset");
    rstN = 1'b1;
    @(negedge clk);
    commitCfg();
    checkAll('0, 43, "R9 commit after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule